// File: doc/BRIEF.md
# Dual-Channel ADPCM Mode and Bypass Controller

This block sits between the serial ports and the compression core of a two-channel voice transcoder. It holds the operating mode of each voice channel (B1 and B2) and moves data between the 8-bit PCM side and the 4-bit ADPCM side. Each channel's 2-bit select is sampled once per frame on a frame tick. The captured sample is handed to the compression core, or routed around it in bypass. The result is presented for transmission one frame later.

On each frame tick the block captures one PCM octet and one ADPCM nibble per channel. A frame is spent loading a sample and a frame is spent processing it, so in every mode data leaves two frames after it began to load. When all four select inputs are held at zero across enough consecutive frames, the block raises an algorithm-reset request to the core. The compression arithmetic lives outside the block. The block only feeds the core the captured data and takes back its results, which the core flags with a valid pulse.

Top module: `adpbp_ctrl`

## Requirements
- R1: On each frame tick, each channel latches its select and drives it on its mode code output until the next tick. The code matches the select: 00 = algorithm reset, 01 = bypass, 10 = 24 kbit/s, 11 = 32 kbit/s.
- R2: The B1 select governs only B1 data and the B2 select governs only B2 data, so the two channels can run in different modes in the same frame.
- R3: The reset request rises at the frame tick on which all four select bits have been zero for RST_FRAMES (default 4) consecutive ticks, and not at any earlier tick. A nonzero tick in between restarts the count.
- R4: Once raised, the reset request stays high through every further all-zero tick. It drops at the first tick that samples a nonzero select.
- R5: If only one channel's select is 00, no reset request is raised. That channel transmits zero on both its PCM and ADPCM outputs for the frame it governs.
- R6: In bypass, the outgoing PCM octet carries the captured ADPCM nibble in bits 7:4 and zero in bits 3:0. The outgoing ADPCM word is bits 7:4 of the captured PCM octet.
- R7: Values presented at frame tick k appear on the transmit outputs after tick k+1, in every mode including bypass, and hold until tick k+2.
- R8: A sample is handled in the mode sampled at the same tick that captured it, so a channel can alternate between 24 and 32 kbit/s from one frame to the next.
- R9: In 24 kbit/s mode, the transmitted ADPCM word is bits 3:1 of the core result with bit 0 forced to zero. The nibble fed to the core also has bit 0 cleared.
- R10: In 32 kbit/s mode, the channel transmits the core's PCM and ADPCM results as returned during the processing frame. The core is fed the captured octet and nibble unchanged.
- R11: After reset, all outputs are zero, both mode codes read 00 and the reset request is low.
- R12: Transmit outputs change only on the cycle after a frame tick. Core results arriving mid-frame do not disturb them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse at each frame boundary |
| mode_sel_b1 | input | 2 | Mode select for channel B1 |
| mode_sel_b2 | input | 2 | Mode select for channel B2 |
| pcm_in_b1 | input | PCM_W | Received PCM octet, channel B1 |
| pcm_in_b2 | input | PCM_W | Received PCM octet, channel B2 |
| adp_in_b1 | input | ADP_W | Received ADPCM nibble, channel B1 |
| adp_in_b2 | input | ADP_W | Received ADPCM nibble, channel B2 |
| core_valid | input | 1 | Core results valid this cycle |
| core_pcm_b1 | input | PCM_W | Core decoded octet, channel B1 |
| core_pcm_b2 | input | PCM_W | Core decoded octet, channel B2 |
| core_adp_b1 | input | ADP_W | Core encoded word, channel B1 |
| core_adp_b2 | input | ADP_W | Core encoded word, channel B2 |
| core_pcm_src_b1 | output | PCM_W | Octet fed to the core, channel B1 |
| core_pcm_src_b2 | output | PCM_W | Octet fed to the core, channel B2 |
| core_adp_src_b1 | output | ADP_W | Nibble fed to the core, channel B1 |
| core_adp_src_b2 | output | ADP_W | Nibble fed to the core, channel B2 |
| mode_b1 | output | 2 | Active mode code, channel B1 |
| mode_b2 | output | 2 | Active mode code, channel B2 |
| rst_req | output | 1 | Algorithm-reset request to the core |
| pcm_tx_b1 | output | PCM_W | PCM octet to transmit, channel B1 |
| pcm_tx_b2 | output | PCM_W | PCM octet to transmit, channel B2 |
| adp_tx_b1 | output | ADP_W | ADPCM word to transmit, channel B1 |
| adp_tx_b2 | output | ADP_W | ADPCM word to transmit, channel B2 |

## Verification
The bench walks the two channels through mixed modes and switches one channel between 24 and 32 kbit/s on consecutive frames. A design that applied the mode of the frame in which the output was emitted, rather than the frame that captured the sample, would then send a word with the wrong low bit.

Bypass vectors pick nibbles whose upper and lower halves differ. This exposes a swapped nibble, a non-zero low half, or data taken a frame too early.

The reset-request test drives three all-zero frames, one nonzero frame and then five all-zero frames. A counter that fails to restart, or fires one frame early, raises the request on a tick where it must stay low. A request that lingers after the selects change is caught on the following tick. A single channel held at 00 must yield zeros on that channel and no request.

// File: rtl/adpbp_pkg.sv
package adpbp_pkg;

  typedef enum logic [1:0] {
    MD_RESET  = 2'b00,
    MD_BYPASS = 2'b01,
    MD_R24    = 2'b10,
    MD_R32    = 2'b11
  } chan_mode_e;

  function automatic logic [3:0] clear_lsb4(input logic [3:0] v);
    return {v[3:1], 1'b0};
  endfunction

endpackage

// File: rtl/adpbp_rst_detect.sv
module adpbp_rst_detect #(
  parameter int RST_FRAMES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic all_zero_i,
  output logic req_o
);
  localparam int CNT_W = $clog2(RST_FRAMES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RST_FRAMES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  // saturating count of consecutive all-zero ticks
  assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      req_o <= 1'b0;
    end else if (tick_i) begin
      if (all_zero_i) begin
        cnt_q <= cnt_inc;
        req_o <= (cnt_inc == CNT_MAX);
      end else begin
        cnt_q <= '0;
        req_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adpbp_lane.sv
module adpbp_lane
  import adpbp_pkg::*;
#(
  parameter int PCM_W = 8,
  parameter int ADP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [1:0]       sel_i,
  input  logic [PCM_W-1:0] pcm_i,
  input  logic [ADP_W-1:0] adp_i,
  input  logic             core_valid_i,
  input  logic [PCM_W-1:0] core_pcm_i,
  input  logic [ADP_W-1:0] core_adp_i,
  output logic [PCM_W-1:0] pcm_src_o,
  output logic [ADP_W-1:0] adp_src_o,
  output logic [1:0]       mode_o,
  output logic [PCM_W-1:0] pcm_tx_o,
  output logic [ADP_W-1:0] adp_tx_o
);
  localparam int PAD_W = PCM_W - ADP_W;

  chan_mode_e       sel_m;
  chan_mode_e       mode_q;
  logic [ADP_W-1:0] adp_stage_q;
  logic [ADP_W-1:0] pcm_hi_q;
  logic [PCM_W-1:0] res_pcm_q;
  logic [ADP_W-1:0] res_adp_q;
  logic [ADP_W-1:0] adp_lsb0;
  logic [ADP_W-1:0] res_lsb0;

  assign sel_m    = chan_mode_e'(sel_i);
  assign adp_lsb0 = {adp_i[ADP_W-1:1], 1'b0};
  assign res_lsb0 = {res_adp_q[ADP_W-1:1], 1'b0};
  assign mode_o   = mode_q;

  // stage 1: capture at the tick, mode bound to the captured sample
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MD_RESET;
      adp_stage_q <= '0;
      pcm_hi_q    <= '0;
      pcm_src_o   <= '0;
      adp_src_o   <= '0;
    end else if (tick_i) begin
      mode_q      <= sel_m;
      adp_stage_q <= adp_i;
      pcm_hi_q    <= pcm_i[PCM_W-1 -: ADP_W];
      case (sel_m)
        MD_RESET: begin
          pcm_src_o <= '0;
          adp_src_o <= '0;
        end
        MD_R24: begin
          pcm_src_o <= pcm_i;
          adp_src_o <= adp_lsb0;
        end
        default: begin
          pcm_src_o <= pcm_i;
          adp_src_o <= adp_i;
        end
      endcase
    end
  end

  // core result holding for the processing frame
  always_ff @(posedge clk) begin
    if (rst) begin
      res_pcm_q <= '0;
      res_adp_q <= '0;
    end else if (core_valid_i) begin
      res_pcm_q <= core_pcm_i;
      res_adp_q <= core_adp_i;
    end else if (tick_i) begin
      res_pcm_q <= '0;
      res_adp_q <= '0;
    end
  end

  // stage 2: transmit registers loaded at the end of the processing frame
  always_ff @(posedge clk) begin
    if (rst) begin
      pcm_tx_o <= '0;
      adp_tx_o <= '0;
    end else if (tick_i) begin
      case (mode_q)
        MD_RESET: begin
          pcm_tx_o <= '0;
          adp_tx_o <= '0;
        end
        MD_BYPASS: begin
          pcm_tx_o <= {adp_stage_q, {PAD_W{1'b0}}};
          adp_tx_o <= pcm_hi_q;
        end
        MD_R24: begin
          pcm_tx_o <= res_pcm_q;
          adp_tx_o <= res_lsb0;
        end
        default: begin
          pcm_tx_o <= res_pcm_q;
          adp_tx_o <= res_adp_q;
        end
      endcase
    end
  end
endmodule

// File: rtl/adpbp_ctrl.sv
module adpbp_ctrl #(
  parameter int PCM_W      = 8,
  parameter int ADP_W      = 4,
  parameter int RST_FRAMES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_tick,
  input  logic [1:0]       mode_sel_b1,
  input  logic [1:0]       mode_sel_b2,
  input  logic [PCM_W-1:0] pcm_in_b1,
  input  logic [PCM_W-1:0] pcm_in_b2,
  input  logic [ADP_W-1:0] adp_in_b1,
  input  logic [ADP_W-1:0] adp_in_b2,
  input  logic             core_valid,
  input  logic [PCM_W-1:0] core_pcm_b1,
  input  logic [PCM_W-1:0] core_pcm_b2,
  input  logic [ADP_W-1:0] core_adp_b1,
  input  logic [ADP_W-1:0] core_adp_b2,
  output logic [PCM_W-1:0] core_pcm_src_b1,
  output logic [PCM_W-1:0] core_pcm_src_b2,
  output logic [ADP_W-1:0] core_adp_src_b1,
  output logic [ADP_W-1:0] core_adp_src_b2,
  output logic [1:0]       mode_b1,
  output logic [1:0]       mode_b2,
  output logic             rst_req,
  output logic [PCM_W-1:0] pcm_tx_b1,
  output logic [PCM_W-1:0] pcm_tx_b2,
  output logic [ADP_W-1:0] adp_tx_b1,
  output logic [ADP_W-1:0] adp_tx_b2
);
  localparam int NCH = 2;

  logic [1:0]       sel_a     [NCH];
  logic [PCM_W-1:0] pcm_a     [NCH];
  logic [ADP_W-1:0] adp_a     [NCH];
  logic [PCM_W-1:0] cpcm_a    [NCH];
  logic [ADP_W-1:0] cadp_a    [NCH];
  logic [PCM_W-1:0] psrc_a    [NCH];
  logic [ADP_W-1:0] asrc_a    [NCH];
  logic [1:0]       mode_a    [NCH];
  logic [PCM_W-1:0] ptx_a     [NCH];
  logic [ADP_W-1:0] atx_a     [NCH];

  assign sel_a[0]  = mode_sel_b1;  assign sel_a[1]  = mode_sel_b2;
  assign pcm_a[0]  = pcm_in_b1;    assign pcm_a[1]  = pcm_in_b2;
  assign adp_a[0]  = adp_in_b1;    assign adp_a[1]  = adp_in_b2;
  assign cpcm_a[0] = core_pcm_b1;  assign cpcm_a[1] = core_pcm_b2;
  assign cadp_a[0] = core_adp_b1;  assign cadp_a[1] = core_adp_b2;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    adpbp_lane #(.PCM_W(PCM_W), .ADP_W(ADP_W)) u_lane (
      .clk          (clk),
      .rst          (rst),
      .tick_i       (frame_tick),
      .sel_i        (sel_a[ch]),
      .pcm_i        (pcm_a[ch]),
      .adp_i        (adp_a[ch]),
      .core_valid_i (core_valid),
      .core_pcm_i   (cpcm_a[ch]),
      .core_adp_i   (cadp_a[ch]),
      .pcm_src_o    (psrc_a[ch]),
      .adp_src_o    (asrc_a[ch]),
      .mode_o       (mode_a[ch]),
      .pcm_tx_o     (ptx_a[ch]),
      .adp_tx_o     (atx_a[ch])
    );
  end

  adpbp_rst_detect #(.RST_FRAMES(RST_FRAMES)) u_rst_detect (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (frame_tick),
    .all_zero_i ((mode_sel_b1 == 2'b00) && (mode_sel_b2 == 2'b00)),
    .req_o      (rst_req)
  );

  assign core_pcm_src_b1 = psrc_a[0];  assign core_pcm_src_b2 = psrc_a[1];
  assign core_adp_src_b1 = asrc_a[0];  assign core_adp_src_b2 = asrc_a[1];
  assign mode_b1         = mode_a[0];  assign mode_b2         = mode_a[1];
  assign pcm_tx_b1       = ptx_a[0];   assign pcm_tx_b2       = ptx_a[1];
  assign adp_tx_b1       = atx_a[0];   assign adp_tx_b2       = atx_a[1];
endmodule

// File: rtl/adpbp_ctrl_chk.sv
module adpbp_ctrl_chk #(
  parameter int PCM_W = 8,
  parameter int ADP_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_tick,
  input logic [1:0]       mode_sel_b1,
  input logic [1:0]       mode_sel_b2,
  input logic [1:0]       mode_b1,
  input logic [1:0]       mode_b2,
  input logic             rst_req,
  input logic [PCM_W-1:0] pcm_tx_b1,
  input logic [PCM_W-1:0] pcm_tx_b2,
  input logic [ADP_W-1:0] adp_tx_b1,
  input logic [ADP_W-1:0] adp_tx_b2
);
  localparam int PAD_W = PCM_W - ADP_W;

  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_tick) |-> ($stable(mode_b1) && $stable(mode_b2)));

  assert_req_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> ($past(frame_tick) && $past(mode_sel_b1) == 2'b00 &&
                        $past(mode_sel_b2) == 2'b00));

  assert_req_both_reset_R5: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (mode_b1 == 2'b00 && mode_b2 == 2'b00));

  assert_bypass_low_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(frame_tick) && $past(mode_b1) == 2'b01) |-> (pcm_tx_b1[PAD_W-1:0] == '0));

  assert_r24_lsb_b1_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(frame_tick) && $past(mode_b1) == 2'b10) |-> (adp_tx_b1[0] == 1'b0));

  assert_r24_lsb_b2_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(frame_tick) && $past(mode_b2) == 2'b10) |-> (adp_tx_b2[0] == 1'b0));

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_tick) |-> ($stable(pcm_tx_b1) && $stable(pcm_tx_b2) &&
                            $stable(adp_tx_b1) && $stable(adp_tx_b2)));
endmodule

bind adpbp_ctrl adpbp_ctrl_chk #(.PCM_W(PCM_W), .ADP_W(ADP_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_tick  (frame_tick),
  .mode_sel_b1 (mode_sel_b1),
  .mode_sel_b2 (mode_sel_b2),
  .mode_b1     (mode_b1),
  .mode_b2     (mode_b2),
  .rst_req     (rst_req),
  .pcm_tx_b1   (pcm_tx_b1),
  .pcm_tx_b2   (pcm_tx_b2),
  .adp_tx_b1   (adp_tx_b1),
  .adp_tx_b2   (adp_tx_b2)
);

// File: tb/tb_adpbp_ctrl.sv
`timescale 1ns/1ps
module tb_adpbp_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_tick = 1'b0;
  logic [1:0] mode_sel_b1 = 2'b11, mode_sel_b2 = 2'b11;
  logic [7:0] pcm_in_b1 = '0, pcm_in_b2 = '0;
  logic [3:0] adp_in_b1 = '0, adp_in_b2 = '0;
  logic       core_valid = 1'b0;
  logic [7:0] core_pcm_b1 = '0, core_pcm_b2 = '0;
  logic [3:0] core_adp_b1 = '0, core_adp_b2 = '0;
  logic [7:0] core_pcm_src_b1, core_pcm_src_b2;
  logic [3:0] core_adp_src_b1, core_adp_src_b2;
  logic [1:0] mode_b1, mode_b2;
  logic       rst_req;
  logic [7:0] pcm_tx_b1, pcm_tx_b2;
  logic [3:0] adp_tx_b1, adp_tx_b2;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  adpbp_ctrl dut (.*);

  // {s1,s2,p1,p2,a1,a2,cp1,cp2,ca1,ca2,ep1,ep2,ea1,ea2}
  localparam int NV = 7;
  localparam logic [75:0] VEC [NV] = '{
    {2'b11,2'b11,8'h5A,8'hC3,4'h9,4'h6,8'h12,8'h34,4'hB,4'h7,8'h12,8'h34,4'hB,4'h7},
    {2'b01,2'b01,8'hA7,8'h3C,4'h5,4'hE,8'h99,8'h88,4'h1,4'h2,8'h50,8'hE0,4'hA,4'h3},
    {2'b10,2'b11,8'h11,8'h22,4'hF,4'hF,8'h77,8'h66,4'hF,4'hD,8'h77,8'h66,4'hE,4'hD},
    {2'b11,2'b10,8'h00,8'hFF,4'h0,4'h1,8'hAB,8'hCD,4'h3,4'h9,8'hAB,8'hCD,4'h3,4'h8},
    {2'b01,2'b10,8'hF0,8'h0F,4'hC,4'h3,8'h55,8'h44,4'h6,4'hB,8'hC0,8'h44,4'hF,4'hA},
    {2'b00,2'b11,8'h81,8'h18,4'h7,4'h7,8'h21,8'h43,4'h5,4'h4,8'h00,8'h43,4'h0,4'h4},
    {2'b10,2'b01,8'h6D,8'h9B,4'h2,4'h8,8'h3C,8'h5C,4'h1,4'hF,8'h3C,8'h80,4'h0,4'h9}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
  endtask

  task automatic pulse_core(input logic [75:0] v);
    @(negedge clk);
    core_pcm_b1 = v[47:40]; core_pcm_b2 = v[39:32];
    core_adp_b1 = v[31:28]; core_adp_b2 = v[27:24];
    core_valid  = 1'b1;
    @(negedge clk) core_valid = 1'b0;
    core_pcm_b1 = 8'hEE; core_pcm_b2 = 8'hEE;
    core_adp_b1 = 4'h5;  core_adp_b2 = 4'h5;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11", "pcm_tx_b1", pcm_tx_b1, 0);
    check("R11", "adp_tx_b2", adp_tx_b2, 0);
    check("R11", "mode_b1",   mode_b1,   0);
    check("R11", "rst_req",   rst_req,   0);

    // vector walk: entry i captured at tick i, emitted at tick i+1
    for (int i = 0; i <= NV; i++) begin
      logic [75:0] cur, prev;
      logic [3:0]  exp_src;
      cur  = (i < NV) ? VEC[i] : {2'b11, 2'b11, 72'h0};
      prev = (i > 0) ? VEC[i-1] : 76'h0;
      @(negedge clk);
      mode_sel_b1 = cur[75:74]; mode_sel_b2 = cur[73:72];
      pcm_in_b1   = cur[71:64]; pcm_in_b2   = cur[63:56];
      adp_in_b1   = cur[55:52]; adp_in_b2   = cur[51:48];
      pulse_tick();
      // R7 latency; R2/R6/R8/R9/R10 per-channel result of entry i-1
      check("R7", "pcm_tx_b1", pcm_tx_b1, prev[23:16]);
      check("R2", "pcm_tx_b2", pcm_tx_b2, prev[15:8]);
      check("R8", "adp_tx_b1", adp_tx_b1, prev[7:4]);
      check("R6", "adp_tx_b2", adp_tx_b2, prev[3:0]);
      check("R1", "mode_b1", mode_b1, cur[75:74]);
      check("R1", "mode_b2", mode_b2, cur[73:72]);
      check("R5", "rst_req", rst_req, 0);
      exp_src = (cur[75:74] == 2'b10) ? (cur[55:52] & 4'hE) :
                (cur[75:74] == 2'b00) ? 4'h0 : cur[55:52];
      check("R9", "core_adp_src_b1", core_adp_src_b1, exp_src);
      if (cur[75:74] == 2'b11)
        check("R10", "core_pcm_src_b1", core_pcm_src_b1, cur[71:64]);
      if (i < NV) begin
        pulse_core(cur);
        check("R12", "pcm_tx_b1 mid-frame", pcm_tx_b1, prev[23:16]);
        check("R12", "adp_tx_b2 mid-frame", adp_tx_b2, prev[3:0]);
      end
    end

    // R3: three all-zero ticks, a break, then a full run
    @(negedge clk); mode_sel_b1 = 2'b00; mode_sel_b2 = 2'b00;
    for (int k = 0; k < 3; k++) begin
      pulse_tick();
      check("R3", "rst_req before break", rst_req, 0);
    end
    @(negedge clk); mode_sel_b2 = 2'b10;
    pulse_tick();
    check("R3", "rst_req at break", rst_req, 0);
    @(negedge clk); mode_sel_b2 = 2'b00;
    for (int k = 1; k <= 3; k++) begin
      pulse_tick();
      check("R3", "rst_req early", rst_req, 0);
    end
    pulse_tick();
    check("R3", "rst_req fourth tick", rst_req, 1);
    check("R1", "mode_b2 reset", mode_b2, 0);
    repeat (4) @(negedge clk);
    check("R4", "rst_req mid-frame", rst_req, 1);
    pulse_tick();
    check("R4", "rst_req sustained", rst_req, 1);
    @(negedge clk); mode_sel_b1 = 2'b11;
    pulse_tick();
    check("R4", "rst_req released", rst_req, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule